// File: doc/BRIEF.md
# Interval Timer with Idle Power-Down Countdown

This block turns a free-running oscillator tick into two timing events for a low-power handheld system. It divides the tick by a fixed binary prescaler of 2^PRESCALE_BITS. The prescaler feeds an interval counter whose period can be programmed. Each time the interval counter completes a period it emits a single-cycle interrupt pulse and reloads itself. With the default divide-by-512 and a period of 79, the pulse arrives at roughly 20 Hz on the faster oscillator. A period of 53 gives a similar rate on an oscillator running at about two thirds of that speed.

Each interrupt pulse also steps an idle countdown by one. Every key press reloads the countdown to its reload value, which defaults to 6000. When the countdown reaches zero, the block raises a power-down request. The request stays up until the user presses a key. Software writes the interval period and the countdown reload value through a small write port. An enable input freezes the countdown when idle shutdown is not wanted.

Top module: `apd_interval_timer`

## Requirements
- R1: The interval counter advances once every 2^PRESCALE_BITS cycles in which `osc_tick_i` is high (default 512). Cycles with `osc_tick_i` low are not counted.
- R2: `irq_o` is high for exactly one cycle after the Nth prescaled step, where N is the programmed period (default 79). The counter then reloads by itself and the next period begins at once.
- R3: A write with `wr_sel_i` = 0 stores `wr_data_i[IVL_W-1:0]` as the new period. The new period applies only from the next reload, so the count already in progress finishes with the old period. A stored period of 0 behaves as 1.
- R4: Each `irq_o` pulse decrements the idle countdown by one. When the countdown reaches zero, `pd_req_o` goes high in the cycle after that pulse.
- R5: A key press reloads the countdown with the reload value and lowers `pd_req_o` in the next cycle. The reload value defaults to 6000 and is written with `wr_sel_i` = 1 from `wr_data_i[APD_W-1:0]`.
- R6: If a key press and an `irq_o` step fall in the same cycle, the key press wins: the countdown reloads to the full reload value and is not decremented.
- R7: Once it reaches zero, the countdown stays at zero and does not wrap. `pd_req_o` stays high through any further pulses until a key press.
- R8: While `apd_en_i` is low, the countdown holds its value and `pd_req_o` is low. When the enable returns high, counting resumes from the held value.
- R9: While reset is asserted, and directly after it is released, `irq_o` and `pd_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| osc_tick_i | input | 1 | Oscillator tick enable, one count per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the interval period, 1 selects the countdown reload value |
| wr_data_i | input | DATA_W | Write data |
| key_press_i | input | 1 | Key-press strobe |
| apd_en_i | input | 1 | Idle countdown enable |
| irq_o | output | 1 | Periodic interrupt pulse |
| pd_req_o | output | 1 | Power-down request |

## Verification
A key press and an interval step can fall in the same cycle. The step is the cycle in which `irq_o` is high. The bench provokes the collision by waiting for the rising edge of `irq_o` and raising `key_press_i` for exactly that cycle, at a point where the countdown already sits one step below the reload value. The outcome is judged by the number of further pulses before `pd_req_o` rises. If the key press wins, the full reload count is needed. If the step is wrongly applied, the request comes early and the bench sees it high where it expects it low.

// File: rtl/apd_timer_pkg.sv
`timescale 1ns/1ps
package apd_timer_pkg;

  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_RELOAD = 1'b1
  } wr_target_e;

  localparam int unsigned DEF_PRESCALE_BITS = 9;
  localparam int unsigned DEF_IVL_W         = 8;
  localparam int unsigned DEF_APD_W         = 13;
  localparam int unsigned DEF_DATA_W        = 16;
  localparam int unsigned DEF_PERIOD        = 79;
  localparam int unsigned DEF_RELOAD        = 6000;

endpackage

// File: rtl/apd_rst_sync.sv
`timescale 1ns/1ps
module apd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync_o = sync_q[1];

endmodule

// File: rtl/apd_prescaler.sv
`timescale 1ns/1ps
module apd_prescaler #(
  parameter int unsigned PRESCALE_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic stb_o
);

  logic [PRESCALE_BITS-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  assign stb_o = tick_i && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Idle oscillator cycles leave the divider untouched.
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  // A strobe marks the wrap of the divider.
  assert_wrap_on_stb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> (cnt_q == '0));

endmodule

// File: rtl/apd_interval_ctr.sv
`timescale 1ns/1ps
module apd_interval_ctr #(
  parameter int unsigned IVL_W      = 8,
  parameter int unsigned DEF_PERIOD = 79
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic             wr_i,
  input  logic [IVL_W-1:0] wr_val_i,
  output logic             irq_o
);

  localparam logic [IVL_W-1:0] PERIOD_RST = IVL_W'(DEF_PERIOD);
  localparam logic [IVL_W-1:0] ONE        = IVL_W'(1);

  logic [IVL_W-1:0] period_q, period_d;
  logic [IVL_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             last_step;
  logic [IVL_W-1:0] reload_val;

  assign last_step  = (cnt_q <= ONE);
  assign reload_val = (period_q == '0) ? ONE : period_q;

  always_comb begin
    period_d = period_q;
    if (wr_i) period_d = wr_val_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    if (stb_i) begin
      if (last_step) begin
        cnt_d = reload_val;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PERIOD_RST;
      cnt_q    <= PERIOD_RST;
      irq_q    <= 1'b0;
    end else begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
      irq_q    <= irq_d;
    end
  end

  assign irq_o = irq_q;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // The count moves only on a prescaled strobe.
  assert_count_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(cnt_q));

  // A write never disturbs the running count.
  assert_write_deferred_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !stb_i) |=> $stable(cnt_q));

endmodule

// File: rtl/apd_countdown.sv
`timescale 1ns/1ps
module apd_countdown #(
  parameter int unsigned APD_W      = 13,
  parameter int unsigned DEF_RELOAD = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             key_i,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [APD_W-1:0] wr_val_i,
  output logic             pd_req_o
);

  localparam logic [APD_W-1:0] RELOAD_RST = APD_W'(DEF_RELOAD);

  logic [APD_W-1:0] reload_q, reload_d;
  logic [APD_W-1:0] cnt_q, cnt_d;
  logic             pd_q, pd_d;

  always_comb begin
    reload_d = reload_q;
    if (wr_i) reload_d = wr_val_i;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (key_i)                                 cnt_d = reload_q;
    else if (en_i && step_i && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    pd_d = 1'b0;
    if (!key_i && en_i) pd_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      cnt_q    <= RELOAD_RST;
      pd_q     <= 1'b0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      pd_q     <= pd_d;
    end
  end

  assign pd_req_o = pd_q;

  assert_key_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_i |=> !pd_q);

  assert_key_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (key_i && step_i) |=> (cnt_q == $past(reload_q)));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !key_i) |=> (cnt_q == '0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && en_i && !key_i) |=> pd_q);

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pd_q);

  assert_disabled_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !key_i) |=> $stable(cnt_q));

endmodule

// File: rtl/apd_interval_timer.sv
`timescale 1ns/1ps
module apd_interval_timer
  import apd_timer_pkg::*;
#(
  parameter int unsigned PRESCALE_BITS = DEF_PRESCALE_BITS,
  parameter int unsigned IVL_W         = DEF_IVL_W,
  parameter int unsigned APD_W         = DEF_APD_W,
  parameter int unsigned DATA_W        = DEF_DATA_W,
  parameter int unsigned PERIOD_INIT   = DEF_PERIOD,
  parameter int unsigned RELOAD_INIT   = DEF_RELOAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              key_press_i,
  input  logic              apd_en_i,
  output logic              irq_o,
  output logic              pd_req_o
);

  logic rst_n_int;
  logic presc_stb;
  logic wr_period, wr_reload;
  logic irq_int;

  assign wr_period = wr_en_i && (wr_target_e'(wr_sel_i) == SEL_PERIOD);
  assign wr_reload = wr_en_i && (wr_target_e'(wr_sel_i) == SEL_RELOAD);

  apd_rst_sync u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  apd_prescaler #(.PRESCALE_BITS(PRESCALE_BITS)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .tick_i (osc_tick_i),
    .stb_o  (presc_stb)
  );

  apd_interval_ctr #(.IVL_W(IVL_W), .DEF_PERIOD(PERIOD_INIT)) u_ivl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .stb_i    (presc_stb),
    .wr_i     (wr_period),
    .wr_val_i (wr_data_i[IVL_W-1:0]),
    .irq_o    (irq_int)
  );

  apd_countdown #(.APD_W(APD_W), .DEF_RELOAD(RELOAD_INIT)) u_apd (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .step_i   (irq_int),
    .key_i    (key_press_i),
    .en_i     (apd_en_i),
    .wr_i     (wr_reload),
    .wr_val_i (wr_data_i[APD_W-1:0]),
    .pd_req_o (pd_req_o)
  );

  assign irq_o = irq_int;

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n_int |=> (!irq_o && !pd_req_o));

endmodule

// File: tb/apd_interval_timer_bench.sv
`timescale 1ns/1ps
module apd_interval_timer_bench;

  localparam int unsigned PB   = 3;
  localparam int unsigned DIV  = 1 << PB;
  localparam int unsigned DW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc_tick_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          wr_sel_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          key_press_i = 1'b0;
  logic          apd_en_i = 1'b1;
  logic          irq_o, pd_req_o;

  int tests = 0;
  int fails = 0;
  int tick_sent = 0;
  int irq_seen = 0;
  bit tick_run = 1'b0;
  bit finished = 1'b0;
  bit prev_irq = 1'b0;
  int exp_q[$];

  always #4 clk = ~clk;

  apd_interval_timer #(.PRESCALE_BITS(PB), .DATA_W(DW)) u_apd_interval_timer (
    .clk(clk), .rst_n(rst_n), .osc_tick_i(osc_tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .key_press_i(key_press_i),
    .apd_en_i(apd_en_i), .irq_o(irq_o), .pd_req_o(pd_req_o));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver side of the scoreboard: expected tick index of every pulse.
  task automatic plan_irqs();
    exp_q.push_back(79 * DIV);          // R2 default period
    exp_q.push_back(2 * 79 * DIV);
    exp_q.push_back(3 * 79 * DIV);      // R3 old period finishes
    for (int k = 1; k <= 100; k++) exp_q.push_back(3 * 79 * DIV + k * 5 * DIV);
  endtask

  task automatic write_reg(input logic sel, input int val);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = DW'(val);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic press_key();
    @(negedge clk); key_press_i = 1'b1;
    @(negedge clk); key_press_i = 1'b0;
  endtask

  task automatic wait_irqs(input int n);
    int target;
    target = irq_seen + n;
    wait (irq_seen >= target);
    @(posedge clk); #2;
  endtask

  // Oscillator driver: one idle cycle in every five (R1 gating).
  initial begin
    int phase;
    phase = 0;
    wait (tick_run);
    forever begin
      @(negedge clk);
      osc_tick_i = (phase % 5) != 4;
      if (osc_tick_i) tick_sent++;
      phase++;
    end
  end

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (irq_o) begin
        irq_seen++;
        check("R2 pulse width", int'(prev_irq), 0);
        if (exp_q.size() == 0) check("R1 unexpected pulse", tick_sent, -1);
        else check("R1/R2/R3 pulse tick", tick_sent, exp_q.pop_front());
      end
      prev_irq = irq_o;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    plan_irqs();
    repeat (3) @(posedge clk);
    #2;
    check("R9 irq in reset", int'(irq_o), 0);
    check("R9 pd in reset", int'(pd_req_o), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    check("R9 irq after reset", int'(irq_o), 0);
    check("R9 pd after reset", int'(pd_req_o), 0);
    tick_run = 1'b1;

    // R3: change period in the middle of the third count
    wait (tick_sent >= 2 * 79 * DIV + 40);
    write_reg(1'b0, 5);
    // R5: small reload value, then key press to load it
    write_reg(1'b1, 3);
    press_key();
    check("R5 pd low after key", int'(pd_req_o), 0);

    // R4: three steps to zero
    wait_irqs(2);
    check("R4 pd before zero", int'(pd_req_o), 0);
    wait_irqs(1);
    check("R4 pd at zero", int'(pd_req_o), 1);

    // R7: sticky, no wrap
    wait_irqs(2);
    check("R7 pd stays high", int'(pd_req_o), 1);

    // R5: key clears
    press_key();
    check("R5 pd cleared by key", int'(pd_req_o), 0);

    // R8: disabled countdown holds
    @(negedge clk); apd_en_i = 1'b0;
    wait_irqs(4);
    check("R8 pd low while disabled", int'(pd_req_o), 0);
    @(negedge clk); apd_en_i = 1'b1;
    wait_irqs(2);
    check("R8 held count resumes", int'(pd_req_o), 0);
    wait_irqs(1);
    check("R8 pd after resume", int'(pd_req_o), 1);

    // R6: key press in the step cycle
    press_key();
    wait_irqs(1);
    @(posedge irq_o); #1;
    key_press_i = 1'b1;
    @(posedge clk); #1;
    key_press_i = 1'b0;
    wait_irqs(2);
    check("R6 key wins over step", int'(pd_req_o), 0);
    wait_irqs(1);
    check("R6 full reload count", int'(pd_req_o), 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule